// File: doc/BRIEF.md
# PHY Management Register Bank with Interrupts

This block holds the management registers of an Ethernet PHY model and presents them on a plain parallel port. The port carries a 5-bit register address, a write strobe with 16-bit data, and a read strobe. Read data is registered and appears on the clock after the strobe. The bank keeps a control word, a status word, an advertisement word, a pending-event word and an event enable mask. It also answers fixed identity and partner-ability values. Serial framing, line signalling and real negotiation are not modelled.

A link-down input drives the status bits and raises events. A change of that input is registered and applied one clock later. An event that is pending and enabled holds the level interrupt output high. A strobed read of the event word returns its contents and empties it. Writing the control word with its top bit set restores every stored value and then applies the present link state again. A negotiation request written to the control word completes at once.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset, control reads 0x3000, advertisement reads 0x01E1, mask reads 0 and status starts at 0x7809. The current link state is then applied, so with the link held down status stays 0x7809 and the event word holds 0x0010.
- R2: A control write (address 0) with bit 15 clear stores the written value AND 0x7980. If bit 12 of the written value is set, status bit 5 is also set.
- R3: A control write with bit 15 set stores none of its bits. It restores the R1 values in every stored register and clears the mask and the event word. One clock later it applies the link state again (link up gives status 0x782D and events 0x00C0).
- R4: A write to address 4 stores (value AND 0x2D7F) OR 0x0080.
- R5: A write to address 30 stores the low 8 bits as the mask, and reads of address 30 return the mask zero-extended. The interrupt output reflects a new mask from the clock edge of that write.
- R6: A strobed read of address 29 returns the event word as it was before that edge and leaves the word empty after that edge.
- R7: The interrupt output is high exactly when (event word AND mask) is non-zero.
- R8: Link going down clears status bits 2 and 5 and sets event bit 4. Link coming up sets status bits 2 and 5 and sets event bits 7 and 6. Either takes effect two clock edges after the input changes.
- R9: Address 2 reads 0x0007, address 3 reads 0xC0D1, address 5 reads 0x0F71, address 6 reads 0x0001. Address 1 returns the stored status.
- R10: Reads of any other address return 0. Writes to addresses 1, 2, 3, 5, 6, 29 and every unlisted address change nothing.
- R11: A link input held at a steady level raises no further events once it has been applied.
- R12: An event applied on the same edge as a clearing read of address 29 stays in the event word.
- R13: Read data updates only on the edge that samples a read strobe and holds otherwise. Presenting address 29 without a strobe does not clear the event word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| link_down_in | input | 1 | High while the link is down |
| irq_out | output | 1 | Level interrupt |

## Verification
Register writes take effect on the edge that samples the strobe. Mask changes reach the interrupt output right after that edge. Read data is valid after the edge that samples the read strobe. A link input change shows up in status and events two edges after it is driven, and a soft reset applies the link state one edge after the resetting write. The bench drives inputs on falling edges and samples on the next falling edge after the edge where the result is due. It leaves an idle cycle wherever a result needs the second edge. The clear race is set up by issuing the read exactly on the edge where the link event lands.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DW     = 16;
  localparam int ADDR_W = 5;
  localparam int IRQ_W  = 8;

  localparam int A_CTRL    = 0;
  localparam int A_STAT    = 1;
  localparam int A_IDHI    = 2;
  localparam int A_IDLO    = 3;
  localparam int A_ADV     = 4;
  localparam int A_PARTNER = 5;
  localparam int A_EXPN    = 6;
  localparam int A_EVT     = 29;
  localparam int A_MASK    = 30;

  localparam logic [DW-1:0] CTRL_INIT  = 16'h3000;
  localparam logic [DW-1:0] STAT_INIT  = 16'h7809;
  localparam logic [DW-1:0] ADV_INIT   = 16'h01E1;
  localparam logic [DW-1:0] CTRL_KEEP  = 16'h7980;
  localparam logic [DW-1:0] ADV_KEEP   = 16'h2D7F;
  localparam logic [DW-1:0] ADV_FORCE  = 16'h0080;
  localparam logic [DW-1:0] ID_HI_VAL  = 16'h0007;
  localparam logic [DW-1:0] ID_LO_VAL  = 16'hC0D1;
  localparam logic [DW-1:0] PARTNER_V  = 16'h0F71;
  localparam logic [DW-1:0] EXPN_VAL   = 16'h0001;

  localparam int CTRL_SRST  = 15;
  localparam int CTRL_ANGO  = 12;
  localparam int STAT_LINK  = 2;
  localparam int STAT_ANOK  = 5;
  localparam int EV_ENERGY  = 7;
  localparam int EV_ANOK    = 6;
  localparam int EV_DOWN    = 4;

  typedef struct packed {
    logic valid;
    logic down;
  } link_evt_t;
endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker
  import phy_mgmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      link_down_in,
  input  logic      soft_rst,
  output link_evt_t evt
);
  logic link_q, link_d;
  logic applied_q, applied_d;
  logic primed_q, primed_d;
  logic init_q, init_d;

  always_comb begin
    evt.valid = primed_q && !soft_rst && (init_q || (link_q != applied_q));
    evt.down  = link_q;
    link_d    = link_down_in;
    primed_d  = 1'b1;
    init_d    = soft_rst ? 1'b1 : (evt.valid ? 1'b0 : init_q);
    applied_d = evt.valid ? link_q : applied_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q    <= 1'b0;
      applied_q <= 1'b0;
      primed_q  <= 1'b0;
      init_q    <= 1'b1;
    end else begin
      link_q    <= link_d;
      applied_q <= applied_d;
      primed_q  <= primed_d;
      init_q    <= init_d;
    end
  end

  // R11: once applied, a level that does not move raises nothing
  p_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(link_q) && !init_q && $past(!init_q)) |-> !evt.valid);
endmodule

// File: rtl/phy_basic_regs.sv
module phy_basic_regs
  import phy_mgmt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          adv_wr,
  input  logic [DW-1:0] wdata,
  input  link_evt_t     evt,
  output logic          soft_rst,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] adv_q
);
  logic [DW-1:0] ctrl_d, stat_d, adv_d;

  assign soft_rst = ctrl_wr && wdata[CTRL_SRST];

  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    adv_d  = adv_q;
    if (soft_rst) begin
      ctrl_d = CTRL_INIT;
      stat_d = STAT_INIT;
      adv_d  = ADV_INIT;
    end else begin
      if (ctrl_wr) begin
        ctrl_d = wdata & CTRL_KEEP;
        if (wdata[CTRL_ANGO]) stat_d[STAT_ANOK] = 1'b1;
      end
      if (adv_wr) adv_d = (wdata & ADV_KEEP) | ADV_FORCE;
      if (evt.valid) begin
        stat_d[STAT_LINK] = !evt.down;
        stat_d[STAT_ANOK] = !evt.down;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      stat_q <= STAT_INIT;
      adv_q  <= ADV_INIT;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      adv_q  <= adv_d;
    end
  end

  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[CTRL_SRST]) |=> (ctrl_q == ($past(wdata) & CTRL_KEEP)));
  p_soft_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == CTRL_INIT && adv_q == ADV_INIT));
  p_adv_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_wr && !soft_rst) |=> (adv_q == (($past(wdata) & ADV_KEEP) | ADV_FORCE)));
  p_link_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.valid && evt.down) |=> (!stat_q[STAT_LINK] && !stat_q[STAT_ANOK]));
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_data,
  input  logic             clr_rd,
  input  logic             soft_rst,
  input  link_evt_t        evt,
  output logic [IRQ_W-1:0] src_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq
);
  logic [IRQ_W-1:0] src_d, mask_d, ev_bits;

  always_comb begin
    ev_bits = '0;
    if (evt.valid) begin
      if (evt.down) ev_bits[EV_DOWN] = 1'b1;
      else begin
        ev_bits[EV_ENERGY] = 1'b1;
        ev_bits[EV_ANOK]   = 1'b1;
      end
    end
    src_d  = soft_rst ? '0 : ((clr_rd ? '0 : src_q) | ev_bits);
    mask_d = soft_rst ? '0 : (mask_wr ? mask_data : mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(src_q & mask_q);

  p_mask_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !soft_rst) |=> (mask_q == $past(mask_data)));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !evt.valid) |=> (src_q == '0));
  p_evt_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.valid && evt.down && !soft_rst) |=> src_q[EV_DOWN]);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_BITS-1:0] reg_addr,
  input  logic                 wr_en,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 rd_en,
  output logic [DATA_BITS-1:0] rd_data,
  input  logic                 link_down_in,
  output logic                 irq_out
);
  localparam int MASK_PAD = DATA_BITS - IRQ_W;

  logic          soft_rst, ctrl_wr, adv_wr, mask_wr, clr_rd;
  link_evt_t     evt;
  logic [DW-1:0] ctrl_q, stat_q, adv_q;
  logic [IRQ_W-1:0] src_q, mask_q;
  logic [DATA_BITS-1:0] rd_mux, rd_q, rd_d;

  assign ctrl_wr = wr_en && (reg_addr == ADDR_BITS'(A_CTRL));
  assign adv_wr  = wr_en && (reg_addr == ADDR_BITS'(A_ADV));
  assign mask_wr = wr_en && (reg_addr == ADDR_BITS'(A_MASK));
  assign clr_rd  = rd_en && (reg_addr == ADDR_BITS'(A_EVT));

  phy_basic_regs u_basic (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .adv_wr(adv_wr),
    .wdata(wr_data), .evt(evt), .soft_rst(soft_rst),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .adv_q(adv_q)
  );

  phy_link_tracker u_link (
    .clk(clk), .rst_n(rst_n), .link_down_in(link_down_in),
    .soft_rst(soft_rst), .evt(evt)
  );

  phy_irq_regs u_irq (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr),
    .mask_data(wr_data[IRQ_W-1:0]), .clr_rd(clr_rd), .soft_rst(soft_rst),
    .evt(evt), .src_q(src_q), .mask_q(mask_q), .irq(irq_out)
  );

  always_comb begin
    case (int'(reg_addr))
      A_CTRL:    rd_mux = ctrl_q;
      A_STAT:    rd_mux = stat_q;
      A_IDHI:    rd_mux = ID_HI_VAL;
      A_IDLO:    rd_mux = ID_LO_VAL;
      A_ADV:     rd_mux = adv_q;
      A_PARTNER: rd_mux = PARTNER_V;
      A_EXPN:    rd_mux = EXPN_VAL;
      A_EVT:     rd_mux = {{MASK_PAD{1'b0}}, src_q};
      A_MASK:    rd_mux = {{MASK_PAD{1'b0}}, mask_q};
      default:   rd_mux = '0;
    endcase
    rd_d = rd_en ? rd_mux : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_id_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == ADDR_BITS'(A_IDLO)) |=> (rd_data == ID_LO_VAL));
  p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr == ADDR_BITS'(7)) |=> (rd_data == '0));
  p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !evt.valid && !mask_wr) |=> !irq_out);
endmodule

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        link_down_in = 1'b1;
  logic        irq_out;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  phy_mgmt_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .link_down_in(link_down_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    chk("R1 irq", {15'd0, irq_out}, 16'h0000);
    rd_chk("R1 ctrl", 5'd0, 16'h3000);
    rd_chk("R1 status", 5'd1, 16'h7809);
    rd_chk("R1 adv", 5'd4, 16'h01E1);
    rd_chk("R1 mask", 5'd30, 16'h0000);
    rd_chk("R1 events", 5'd29, 16'h0010);
    rd_chk("R6 cleared", 5'd29, 16'h0000);
  endtask

  task automatic t_fixed;
    rd_chk("R9 reg2", 5'd2, 16'h0007);
    rd_chk("R9 reg3", 5'd3, 16'hC0D1);
    rd_chk("R9 reg5", 5'd5, 16'h0F71);
    rd_chk("R9 reg6", 5'd6, 16'h0001);
  endtask

  task automatic t_unimpl;
    wr(5'd1, 16'hFFFF);
    wr(5'd2, 16'hFFFF);
    wr(5'd29, 16'hFFFF);
    wr(5'd7, 16'hFFFF);
    rd_chk("R10 status kept", 5'd1, 16'h7809);
    rd_chk("R10 id kept", 5'd2, 16'h0007);
    rd_chk("R10 events kept", 5'd29, 16'h0000);
    rd_chk("R10 reg7", 5'd7, 16'h0000);
    rd_chk("R10 reg31", 5'd31, 16'h0000);
  endtask

  task automatic t_link;
    link_down_in = 1'b0;
    idle(2);
    rd_chk("R8 up status", 5'd1, 16'h782D);
    rd_chk("R8 up events", 5'd29, 16'h00C0);
    link_down_in = 1'b1;
    idle(2);
    rd_chk("R8 down status", 5'd1, 16'h7809);
    rd_chk("R8 down events", 5'd29, 16'h0010);
  endtask

  task automatic t_steady;
    idle(10);
    rd_chk("R11 no new events", 5'd29, 16'h0000);
  endtask

  task automatic t_ctrl;
    wr(5'd0, 16'h6FFF);
    rd_chk("R2 ctrl masked", 5'd0, 16'h6980);
    rd_chk("R2 no autoneg", 5'd1, 16'h7809);
    wr(5'd0, 16'h1000);
    rd_chk("R2 ctrl", 5'd0, 16'h1000);
    rd_chk("R2 autoneg done", 5'd1, 16'h7829);
  endtask

  task automatic t_adv;
    wr(5'd4, 16'hFFFF);
    rd_chk("R4 all ones", 5'd4, 16'h2DFF);
    wr(5'd4, 16'h0000);
    rd_chk("R4 zero", 5'd4, 16'h0080);
  endtask

  task automatic t_irq;
    wr(5'd30, 16'hFF10);
    rd_chk("R5 mask low byte", 5'd30, 16'h0010);
    link_down_in = 1'b0;
    idle(2);
    chk("R7 masked event", {15'd0, irq_out}, 16'h0000);
    wr(5'd30, 16'h0040);
    chk("R5 irq on mask write", {15'd0, irq_out}, 16'h0001);
    rd_chk("R6 read events", 5'd29, 16'h00C0);
    chk("R6 irq after clear", {15'd0, irq_out}, 16'h0000);
    rd_chk("R6 empty", 5'd29, 16'h0000);
  endtask

  task automatic t_race;
    logic [15:0] v;
    wr(5'd30, 16'h0010);
    link_down_in = 1'b1;
    idle(1);
    rd(5'd29, v);
    chk("R12 read before event", v, 16'h0000);
    chk("R12 irq kept", {15'd0, irq_out}, 16'h0001);
    rd_chk("R12 event survived", 5'd29, 16'h0010);
  endtask

  task automatic t_noclr;
    link_down_in = 1'b0;
    idle(2);
    wr(5'd30, 16'h00C0);
    reg_addr = 5'd29;
    idle(5);
    chk("R13 rd_data held", rd_data, 16'h0010);
    chk("R13 irq still high", {15'd0, irq_out}, 16'h0001);
    rd_chk("R13 events intact", 5'd29, 16'h00C0);
  endtask

  task automatic t_soft;
    wr(5'd30, 16'h00FF);
    wr(5'd4, 16'h0000);
    wr(5'd0, 16'h9FFF);
    chk("R3 irq cleared", {15'd0, irq_out}, 16'h0000);
    idle(1);
    rd_chk("R3 ctrl", 5'd0, 16'h3000);
    rd_chk("R3 adv", 5'd4, 16'h01E1);
    rd_chk("R3 mask", 5'd30, 16'h0000);
    rd_chk("R3 status relinked", 5'd1, 16'h782D);
    rd_chk("R3 events relinked", 5'd29, 16'h00C0);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_fixed();
    t_unimpl();
    t_link();
    t_steady();
    t_ctrl();
    t_adv();
    t_irq();
    t_race();
    t_noclr();
    t_soft();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule